// File: doc/BRIEF.md
# Embedded Core Memory Write Port

This block is a register-mapped slave on a host write bus. Through it the host fills the instruction memory and the data memory of a small embedded core, one 32-bit word per bus write. Each instruction-memory port has three registers. The first is a pointer register that holds a byte offset, an auto-advance flag and a secure-region select. The second is a data register that stores one word at the pointer. The third is a tag register that labels the 256-byte block the pointer is in. Each data-memory port has only the pointer and the data register. The memory arrays are outside the block: the block drives one registered write strobe, with address and data, toward each array.

The host programs a port's pointer once. It then streams words into that port's data register, and with auto-advance set the pointer steps by one word after each store. Several ports keep separate pointers, so the host can fill more than one region in any interleaving. The core fetches block tags through a combinational lookup port.

Every bus write is first classified as one access kind: `ACC_NONE`, `ACC_ICTL`, `ACC_IDATA`, `ACC_ITAG`, `ACC_DCTL` or `ACC_DDATA`. A unique case on that kind then drives the registered memory strobes and the tag store. The block holds no other sequencing state.

Top module: `core_mem_pio`

## Requirements
- R1: After reset, both memory strobes are low, every tag entry reads 0, and every pointer holds offset 0 with auto-advance off and secure off.
- R2: Instruction port p answers at byte address 0x180+16p: its pointer is at +0, its data at +4 and its tag at +8. Data port q answers at 0x1C0+8q: its pointer is at +0 and its data at +4. A write to any other address changes nothing.
- R3: In a pointer write, bits 15:0 are the byte offset, bit 24 enables auto-advance and bit 28 selects secure instruction memory. Data ports ignore bit 28.
- R4: A data-register write whose word index (offset bits 15:2) is inside the memory raises that memory's strobe for exactly one cycle, in the cycle after the bus write. The strobe carries word address offset[15:2] and the written data. Offset bits 1:0 have no effect.
- R5: With auto-advance set, every data write to a port adds 4 to that port's offset, wrapping modulo 2^16. With auto-advance clear, the offset stays the same.
- R6: An instruction store drives `imem_sec` with the secure bit latched in that port's pointer register.
- R7: A data write whose word index is outside the memory raises no strobe, and the pointer still advances.
- R8: A tag write stores bits 15:0 of the bus data into the entry for block offset[15:8]. The lookup port shows the new value from the next cycle. When the block number is beyond the table, the write is dropped.
- R9: The ports keep separate pointers. A write to one port never moves another port's offset.
- R10: Each bus write produces at most one memory strobe. The two strobes are never high together, and neither rises without a bus write in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write valid |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 32 | Host write data |
| tag_rd_blk | input | TBLK_W | Block number for the tag lookup |
| tag_rd_data | output | 16 | Tag of the looked-up block |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_sec | output | 1 | Store goes to the secure instruction array |
| imem_addr | output | IMEM_AW | Instruction memory word address |
| imem_wdata | output | 32 | Instruction memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | DMEM_AW | Data memory word address |
| dmem_wdata | output | 32 | Data memory write data |

## Verification
The bench builds the block with 256 instruction words and 64 data words. With these sizes the tag table has only four blocks, and the top of both memories and the 16-bit offset wrap can each be reached within a few writes. It sweeps every port of both kinds with interleaved streams. Expected word addresses are computed as base plus a step count, and expected tags as a fixed pattern plus the block number. It also probes unmapped slots inside and outside the two port windows.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ICTL,
        ACC_IDATA,
        ACC_ITAG,
        ACC_DCTL,
        ACC_DDATA
    } acc_e;

    localparam int OFFS_W       = 16;
    localparam int WORD_W       = 32;
    localparam int TAG_W        = 16;
    localparam int BLK_SHIFT    = 8;
    localparam int BLK_NUM_W    = OFFS_W - BLK_SHIFT;
    localparam int CTL_AINC_BIT = 24;
    localparam int CTL_SEC_BIT  = 28;
    localparam int WORD_BYTES   = 4;

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int IMEM_BASE   = 'h180,
    parameter int IMEM_STRIDE = 16,
    parameter int IMEM_PORTS  = 4,
    parameter int DMEM_BASE   = 'h1C0,
    parameter int DMEM_STRIDE = 8,
    parameter int DMEM_PORTS  = 8,
    parameter int PORT_W      = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc,
    output logic [PORT_W-1:0] port
);

    localparam int ISPAN = IMEM_PORTS * IMEM_STRIDE;
    localparam int DSPAN = DMEM_PORTS * DMEM_STRIDE;

    logic [ADDR_W-1:0] irel, drel, islot, dslot;
    logic              in_i, in_d;

    always_comb begin
        irel  = addr - ADDR_W'(IMEM_BASE);
        drel  = addr - ADDR_W'(DMEM_BASE);
        in_i  = (32'(addr) >= IMEM_BASE) && (32'(irel) < ISPAN);
        in_d  = (32'(addr) >= DMEM_BASE) && (32'(drel) < DSPAN);
        islot = (irel % ADDR_W'(IMEM_STRIDE)) >> 2;
        dslot = (drel % ADDR_W'(DMEM_STRIDE)) >> 2;
    end

    always_comb begin
        acc  = ACC_NONE;
        port = '0;
        if (wr_en && in_i) begin
            port = PORT_W'(irel / ADDR_W'(IMEM_STRIDE));
            if (islot == ADDR_W'(0))      acc = ACC_ICTL;
            else if (islot == ADDR_W'(1)) acc = ACC_IDATA;
            else if (islot == ADDR_W'(2)) acc = ACC_ITAG;
        end else if (wr_en && in_d) begin
            port = PORT_W'(drel / ADDR_W'(DMEM_STRIDE));
            if (dslot == ADDR_W'(0))      acc = ACC_DCTL;
            else if (dslot == ADDR_W'(1)) acc = ACC_DDATA;
        end
    end

endmodule

// File: rtl/pio_ptr.sv
module pio_ptr
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              data_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [OFFS_W-1:0] offs
);

    logic ainc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offs <= '0;
            ainc <= 1'b0;
        end else if (ctl_we) begin
            offs <= wdata[OFFS_W-1:0];
            ainc <= wdata[CTL_AINC_BIT];
        end else if (data_we && ainc) begin
            offs <= offs + OFFS_W'(WORD_BYTES);
        end
    end

    // R9: an idle port keeps its offset
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && !data_we) |=> $stable(offs));

    // R5: one word step per store with auto-advance on
    p_step_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !ctl_we && ainc) |=> (offs == $past(offs) + OFFS_W'(WORD_BYTES)));

endmodule

// File: rtl/pio_tag_table.sv
module pio_tag_table
    import pio_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int BLK_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [BLK_NUM_W-1:0] wblk,
    input  logic [TAG_W-1:0]     wtag,
    input  logic [BLK_W-1:0]     rd_blk,
    output logic [TAG_W-1:0]     rd_tag
);

    logic [TAG_W-1:0] tags [NBLK];
    logic             hit;
    logic [BLK_W-1:0] wsel;

    assign hit  = 32'(wblk) < NBLK;
    assign wsel = wblk[BLK_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) tags[i] <= '0;
        end else if (we && hit) begin
            tags[wsel] <= wtag;
        end
    end

    assign rd_tag = (32'(rd_blk) < NBLK) ? tags[rd_blk] : '0;

    // R8: an accepted tag write is held in its block entry
    p_tag_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> (tags[$past(wsel)] == $past(wtag)));

endmodule

// File: rtl/core_mem_pio.sv
module core_mem_pio
    import pio_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int IMEM_PORTS = 4,
    parameter int DMEM_PORTS = 8,
    parameter int IMEM_WORDS = 1024,
    parameter int DMEM_WORDS = 512,
    localparam int IMEM_AW   = $clog2(IMEM_WORDS),
    localparam int DMEM_AW   = $clog2(DMEM_WORDS),
    localparam int TAG_BLKS  = IMEM_WORDS * WORD_BYTES / (1 << BLK_SHIFT),
    localparam int TBLK_W    = $clog2(TAG_BLKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [TBLK_W-1:0]  tag_rd_blk,
    output logic [15:0]        tag_rd_data,
    output logic               imem_we,
    output logic               imem_sec,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [31:0]        imem_wdata,
    output logic               dmem_we,
    output logic [DMEM_AW-1:0] dmem_addr,
    output logic [31:0]        dmem_wdata
);

    localparam int IPW    = $clog2(IMEM_PORTS);
    localparam int DPW    = $clog2(DMEM_PORTS);
    localparam int PORT_W = (IPW > DPW) ? IPW : DPW;

    acc_e              acc;
    logic [PORT_W-1:0] port;

    pio_decode #(
        .ADDR_W(ADDR_W), .IMEM_BASE('h180), .IMEM_STRIDE(16), .IMEM_PORTS(IMEM_PORTS),
        .DMEM_BASE('h1C0), .DMEM_STRIDE(8), .DMEM_PORTS(DMEM_PORTS), .PORT_W(PORT_W)
    ) u_decode (
        .wr_en (wr_en),
        .addr  (wr_addr),
        .acc   (acc),
        .port  (port)
    );

    logic [OFFS_W-1:0]     i_offs [IMEM_PORTS];
    logic [IMEM_PORTS-1:0] i_sec;
    logic [OFFS_W-1:0]     d_offs [DMEM_PORTS];

    for (genvar p = 0; p < IMEM_PORTS; p++) begin : g_iport
        logic ctl_we, data_we;
        assign ctl_we  = (acc == ACC_ICTL)  && (port == PORT_W'(p));
        assign data_we = (acc == ACC_IDATA) && (port == PORT_W'(p));

        pio_ptr u_ptr (
            .clk (clk), .rst_n (rst_n), .ctl_we (ctl_we), .data_we (data_we),
            .wdata (wr_data), .offs (i_offs[p])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      i_sec[p] <= 1'b0;
            else if (ctl_we) i_sec[p] <= wr_data[CTL_SEC_BIT];
        end
    end

    for (genvar q = 0; q < DMEM_PORTS; q++) begin : g_dport
        logic ctl_we, data_we;
        assign ctl_we  = (acc == ACC_DCTL)  && (port == PORT_W'(q));
        assign data_we = (acc == ACC_DDATA) && (port == PORT_W'(q));

        pio_ptr u_ptr (
            .clk (clk), .rst_n (rst_n), .ctl_we (ctl_we), .data_we (data_we),
            .wdata (wr_data), .offs (d_offs[q])
        );
    end

    logic [OFFS_W-1:0] sel_ioffs, sel_doffs;
    logic              sel_isec;
    logic [OFFS_W-3:0] i_word, d_word;
    logic              i_fits, d_fits;
    logic              unused_lowbits;

    always_comb begin
        sel_ioffs = i_offs[port[IPW-1:0]];
        sel_isec  = i_sec[port[IPW-1:0]];
        sel_doffs = d_offs[port[DPW-1:0]];
        i_word    = sel_ioffs[OFFS_W-1:2];
        d_word    = sel_doffs[OFFS_W-1:2];
        i_fits    = 32'(i_word) < IMEM_WORDS;
        d_fits    = 32'(d_word) < DMEM_WORDS;
    end

    assign unused_lowbits = ^{sel_ioffs[1:0], sel_doffs[1:0]};

    logic imem_we_n, dmem_we_n, tag_we;

    always_comb begin
        imem_we_n = 1'b0;
        dmem_we_n = 1'b0;
        tag_we    = 1'b0;
        unique case (acc)
            ACC_IDATA: imem_we_n = i_fits;
            ACC_DDATA: dmem_we_n = d_fits;
            ACC_ITAG:  tag_we    = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imem_we    <= 1'b0;
            imem_sec   <= 1'b0;
            imem_addr  <= '0;
            imem_wdata <= '0;
            dmem_we    <= 1'b0;
            dmem_addr  <= '0;
            dmem_wdata <= '0;
        end else begin
            imem_we <= imem_we_n;
            dmem_we <= dmem_we_n;
            if (imem_we_n) begin
                imem_sec   <= sel_isec;
                imem_addr  <= i_word[IMEM_AW-1:0];
                imem_wdata <= wr_data;
            end
            if (dmem_we_n) begin
                dmem_addr  <= d_word[DMEM_AW-1:0];
                dmem_wdata <= wr_data;
            end
        end
    end

    pio_tag_table #(.NBLK(TAG_BLKS), .BLK_W(TBLK_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tag_we),
        .wblk   (sel_ioffs[OFFS_W-1:BLK_SHIFT]),
        .wtag   (wr_data[TAG_W-1:0]),
        .rd_blk (tag_rd_blk),
        .rd_tag (tag_rd_data)
    );

    // R10: never two strobes together
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_we && dmem_we));

    // R10: a strobe always follows a bus write
    p_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we || dmem_we) |-> $past(wr_en));

    // R7: stores outside the memory are dropped
    p_drop_far_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_IDATA && !i_fits) |=> !imem_we);

endmodule

// File: tb/test_core_mem_pio.sv
`timescale 1ns/1ps
module test_core_mem_pio;

    localparam int AW = 12;
    localparam int IW = 256;
    localparam int DW = 64;
    localparam logic [31:0] AINC = 32'h0100_0000;
    localparam logic [31:0] SEC  = 32'h1000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    tag_rd_blk = '0;
    logic [15:0]   tag_rd_data;
    logic          imem_we, imem_sec, dmem_we;
    logic [7:0]    imem_addr;
    logic [5:0]    dmem_addr;
    logic [31:0]   imem_wdata, dmem_wdata;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    core_mem_pio #(.ADDR_W(AW), .IMEM_PORTS(4), .DMEM_PORTS(8),
                   .IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_core_mem_pio (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .tag_rd_blk (tag_rd_blk), .tag_rd_data (tag_rd_data),
        .imem_we (imem_we), .imem_sec (imem_sec), .imem_addr (imem_addr),
        .imem_wdata (imem_wdata), .dmem_we (dmem_we), .dmem_addr (dmem_addr),
        .dmem_wdata (dmem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int ic(input int p); return 'h180 + 16 * p; endfunction
    function automatic int dc(input int q); return 'h1C0 + 8 * q;  endfunction

    task automatic exp_i(input string req, input int addr, input logic sec, input logic [31:0] d);
        chk({req, " imem_we"}, 32'(imem_we), 32'd1);
        chk({req, " imem_addr"}, 32'(imem_addr), 32'(addr));
        chk({req, " imem_sec"}, 32'(imem_sec), 32'(sec));
        chk({req, " imem_wdata"}, imem_wdata, d);
        chk("R10 dmem quiet", 32'(dmem_we), 32'd0);
    endtask

    task automatic exp_d(input string req, input int addr, input logic [31:0] d);
        chk({req, " dmem_we"}, 32'(dmem_we), 32'd1);
        chk({req, " dmem_addr"}, 32'(dmem_addr), 32'(addr));
        chk({req, " dmem_wdata"}, dmem_wdata, d);
        chk("R10 imem quiet", 32'(imem_we), 32'd0);
    endtask

    task automatic exp_none(input string req);
        chk({req, " imem_we"}, 32'(imem_we), 32'd0);
        chk({req, " dmem_we"}, 32'(dmem_we), 32'd0);
    endtask

    task automatic exp_tag(input string req, input int b, input logic [15:0] t);
        @(negedge clk);
        tag_rd_blk = 2'(b);
        #1;
        chk(req, 32'(tag_rd_data), 32'(t));
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_none("R1 reset");
        for (int b = 0; b < 4; b++) exp_tag("R1 tag reset", b, 16'h0);
        host_wr(ic(0) + 4, 32'h1111_1111);
        exp_i("R1 ptr zero", 0, 1'b0, 32'h1111_1111);
        host_wr(ic(0) + 4, 32'h2222_2222);
        exp_i("R1 ainc off", 0, 1'b0, 32'h2222_2222);

        // R3 R4 R6 R9 interleaved instruction ports, low offset bits set
        for (int p = 0; p < 4; p++)
            host_wr(ic(p), 32'(p * 'h40 + 3) | AINC | ((p % 2 == 1) ? SEC : 32'h0));
        for (int k = 0; k < 4; k++)
            for (int p = 0; p < 4; p++) begin
                host_wr(ic(p) + 4, 32'hC0DE_0000 | 32'(p << 8) | 32'(k));
                exp_i("R9 R6 R4 istream", p * 16 + k, 1'(p % 2),
                      32'hC0DE_0000 | 32'(p << 8) | 32'(k));
            end

        // R3 R5 R9 interleaved data ports, bit 28 set but ignored
        for (int q = 0; q < 8; q++)
            host_wr(dc(q), 32'(q * 'h20) | AINC | SEC);
        for (int k = 0; k < 3; k++)
            for (int q = 0; q < 8; q++) begin
                host_wr(dc(q) + 4, 32'hD000_0000 | 32'(q << 4) | 32'(k));
                exp_d("R3 R5 dstream", q * 8 + k, 32'hD000_0000 | 32'(q << 4) | 32'(k));
            end

        // R5 without auto-advance
        host_wr(ic(2), 32'h10);
        for (int k = 0; k < 3; k++) begin
            host_wr(ic(2) + 4, 32'(k + 7));
            exp_i("R5 ihold", 4, 1'b0, 32'(k + 7));
        end
        host_wr(dc(5), 32'h8);
        for (int k = 0; k < 2; k++) begin
            host_wr(dc(5) + 4, 32'(k + 9));
            exp_d("R5 dhold", 2, 32'(k + 9));
        end

        // R7 top of memory and 16-bit wrap
        host_wr(ic(1), 32'h3F8 | AINC | SEC);
        host_wr(ic(1) + 4, 32'hA1);
        exp_i("R7 last-1", IW - 2, 1'b1, 32'hA1);
        host_wr(ic(1) + 4, 32'hA2);
        exp_i("R7 last", IW - 1, 1'b1, 32'hA2);
        host_wr(ic(1) + 4, 32'hA3);
        exp_none("R7 idrop1");
        host_wr(ic(1) + 4, 32'hA4);
        exp_none("R7 idrop2");
        host_wr(ic(1), 32'hFFFC | AINC);
        host_wr(ic(1) + 4, 32'hA5);
        exp_none("R7 idrop top");
        host_wr(ic(1) + 4, 32'hA6);
        exp_i("R5 R7 wrap", 0, 1'b0, 32'hA6);
        host_wr(dc(7), 32'hFC | AINC);
        host_wr(dc(7) + 4, 32'hB1);
        exp_d("R7 dlast", DW - 1, 32'hB1);
        host_wr(dc(7) + 4, 32'hB2);
        exp_none("R7 ddrop");

        // R8 tags
        for (int b = 0; b < 4; b++) begin
            host_wr(ic(3), 32'(b * 'h100 + 'h24));
            host_wr(ic(3) + 8, 32'hFFFF_A000 + 32'(b));
            exp_none("R10 tag no strobe");
        end
        for (int b = 0; b < 4; b++) exp_tag("R8 tag store", b, 16'hA000 + 16'(b));
        host_wr(ic(3), 32'h400);
        host_wr(ic(3) + 8, 32'hBEEF);
        for (int b = 0; b < 4; b++) exp_tag("R8 tag drop", b, 16'hA000 + 16'(b));
        host_wr(ic(0), 32'h1F0);
        host_wr(ic(0) + 8, 32'h5A5A);
        exp_tag("R8 tag other port", 1, 16'h5A5A);

        // R2 unmapped addresses
        host_wr(ic(0), 32'h80 | AINC);
        host_wr('h17C, 32'h0000_FFFC);
        exp_none("R2 below");
        host_wr('h18C, 32'h0000_0000);
        exp_none("R2 islot3");
        host_wr('h1BC, 32'h0000_0000);
        exp_none("R2 islot3 p3");
        host_wr('h200, 32'h0000_0004);
        exp_none("R2 above");
        host_wr(ic(0) + 4, 32'hFACE);
        exp_i("R2 ptr intact", 'h20, 1'b0, 32'hFACE);
        exp_tag("R2 tags intact", 0, 16'hA000);

        @(negedge clk);
        exp_none("R4 single cycle");
        finish_run();
    end

endmodule